// File: doc/BRIEF.md
# Pipelined Serpent Block Encryptor

This block encrypts 128-bit plaintext blocks with the Serpent cipher. All 32 rounds are unrolled into a chain of combinational round logic. A register holds the block at every round boundary, so a new plaintext can enter on every clock and a ciphertext leaves on every clock. The input is permuted once on entry and once more on exit. Each round mixes in its round key, applies one of eight 4-bit substitution tables across the block, and runs the linear diffusion step. The last round skips diffusion and mixes in a second key instead.

The 33 round keys sit in a register file inside the block. An outside loader fills it one 128-bit word per clock, while no block is in flight. A two-state controller, IDLE and BUSY, guards the file. IDLE moves to BUSY when a block is accepted. BUSY returns to IDLE once the final stage no longer holds a block and no new block is arriving. In BUSY every key write is dropped, so a key cannot change under a block that is in flight.

Top module: `serpent_pipe`

## Requirements
- R1: After reset, `out_valid` and `busy` are low.
- R2: Each accepted block's ciphertext is C = FP(B32), where B0 = IP(P). IP places input bit 32k+j at output bit 4j+k, for k in 0..3 and j in 0..31. FP is the inverse of IP. A block is accepted on every clock where `in_valid` is high, with no gap needed between blocks.
- R3: Rounds i = 0..30 compute B(i+1) = LT(S(i mod 8)(Bi xor Ki)). Ki is key-file word i. The S-box acts on each nibble of bits 4j..4j+3, with bit 4j as the least significant bit. Table 0 begins 3, 8, 15, 1 for inputs 0..3.
- R4: Round 31 computes B32 = S7(B31 xor K31) xor K32, with no linear transform. K32 is key-file word 32.
- R5: `out_valid` copies `in_valid` delayed by exactly 32 clocks. Ciphertexts leave in the same order their plaintexts entered.
- R6: A key write stores `key_word` at entry `key_idx` only when the controller is IDLE and `in_valid` is low in that clock. A write with `key_idx` of 33 or more changes nothing.
- R7: `busy` rises in the clock after an accepted block. It stays high while any stage holds a valid block, and key writes made during that time are discarded.
- R8: `busy` falls in the clock after the last in-flight block shows `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Plaintext strobe |
| in_block | input | 128 | Plaintext block |
| key_we | input | 1 | Round-key write strobe |
| key_idx | input | 6 | Round-key entry, 0 to 32 |
| key_word | input | 128 | Round-key value |
| out_valid | output | 1 | Ciphertext strobe |
| out_block | output | 128 | Ciphertext block |
| busy | output | 1 | Blocks are in flight, so key writes are locked |

## Verification
A wrong table entry, tap, permutation wire or key index corrupts every ciphertext that passes through the faulty round. The error shows as a mismatch against a word-oriented reference model exactly 32 clocks after the affected plaintext. A broken valid shift shows up in the same clock, either as a missing or misplaced `out_valid` or as the wrong latency. A controller that sits in the wrong state shows up one clock after an accepted block or after the last output, as `busy` at the wrong level. A key write that leaks through the lock corrupts the ciphertext of the next block.

// File: rtl/serpent_pkg.sv
package serpent_pkg;

    localparam int BLK_W  = 128;
    localparam int WORD_W = 32;

    typedef enum logic {ST_IDLE, ST_BUSY} pipe_st_e;

    // Each table: entry n occupies nibble n (entry 0 in the lowest nibble).
    localparam logic [63:0] SBOX_TBL [8] = '{
        64'hC90724DEB56A1F83,
        64'h43D68EB1A50972CF,
        64'h25B04E1DFAC39768,
        64'hE57A421D369C8BF0,
        64'hD7E9A4526B0C38F1,
        64'h176D8E30C9A4B25F,
        64'h0A3DF19EB6485C27,
        64'h6539AC47B28E0FD1
    };

    // Interleave: word k bit j -> bit 4j+k
    function automatic logic [BLK_W-1:0] perm_in(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        for (int j = 0; j < WORD_W; j++)
            for (int k = 0; k < 4; k++)
                y[4*j+k] = x[WORD_W*k+j];
        return y;
    endfunction

    // De-interleave: bit 4j+k -> word k bit j
    function automatic logic [BLK_W-1:0] perm_out(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        for (int j = 0; j < WORD_W; j++)
            for (int k = 0; k < 4; k++)
                y[WORD_W*k+j] = x[4*j+k];
        return y;
    endfunction

    // Substitution on sliced words: column j gathers bit j of each word.
    function automatic logic [BLK_W-1:0] sub_sliced(input int unsigned sel,
                                                    input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] y;
        logic [3:0] n, o;
        logic [63:0] tbl;
        tbl = SBOX_TBL[sel % 8];
        for (int j = 0; j < WORD_W; j++) begin
            n = {x[3*WORD_W+j], x[2*WORD_W+j], x[WORD_W+j], x[j]};
            o = tbl[4*n +: 4];
            y[j]          = o[0];
            y[WORD_W+j]   = o[1];
            y[2*WORD_W+j] = o[2];
            y[3*WORD_W+j] = o[3];
        end
        return y;
    endfunction

    function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] w, input int unsigned s);
        return (w << s) | (w >> (WORD_W - s));
    endfunction

    // Diffusion on sliced words
    function automatic logic [BLK_W-1:0] lin_sliced(input logic [BLK_W-1:0] x);
        logic [WORD_W-1:0] a, b, c, d;
        a = x[31:0]; b = x[63:32]; c = x[95:64]; d = x[127:96];
        a = rotl(a, 13);
        c = rotl(c, 3);
        b = b ^ a ^ c;
        d = d ^ c ^ (a << 3);
        b = rotl(b, 1);
        d = rotl(d, 7);
        a = a ^ b ^ d;
        c = c ^ d ^ (b << 7);
        a = rotl(a, 5);
        c = rotl(c, 22);
        return {d, c, b, a};
    endfunction

endpackage

// File: rtl/serpent_mix_sub.sv
module serpent_mix_sub
    import serpent_pkg::*;
#(
    parameter int RIDX = 0
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [BLK_W-1:0] rkey,
    output logic [BLK_W-1:0] sub_out
);
    localparam int unsigned SEL = RIDX % 8;

    // Key mix and substitution; result stays in the interleaved domain.
    always_comb sub_out = perm_in(sub_sliced(SEL, perm_out(blk ^ rkey)));
endmodule

// File: rtl/serpent_key_file.sv
module serpent_key_file
    import serpent_pkg::*;
#(
    parameter int NKEYS  = 33,
    parameter int KIDX_W = 6
) (
    input  logic                         clk,
    input  logic                         wr_ok,
    input  logic [KIDX_W-1:0]            wr_idx,
    input  logic [BLK_W-1:0]             wr_data,
    output logic [NKEYS-1:0][BLK_W-1:0]  keys
);
    for (genvar k = 0; k < NKEYS; k++) begin : g_ent
        always_ff @(posedge clk) begin
            if (wr_ok && (wr_idx == KIDX_W'(k)))
                keys[k] <= wr_data;
        end
    end
endmodule

// File: rtl/serpent_ctrl.sv
module serpent_ctrl
    import serpent_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic inflight,
    input  logic key_we,
    output logic busy,
    output logic wr_ok
);
    pipe_st_e st_q, st_d;

    always_comb begin
        st_d = (in_valid || inflight) ? ST_BUSY : ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (st_q)
            ST_IDLE: begin
                busy  = 1'b0;
                wr_ok = key_we & ~in_valid;
            end
            ST_BUSY: begin
                busy  = 1'b1;
                wr_ok = 1'b0;
            end
            default: begin
                busy  = 1'b1;
                wr_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/serpent_pipe.sv
module serpent_pipe
    import serpent_pkg::*;
#(
    parameter int ROUNDS = 32,
    parameter int KIDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BLK_W-1:0]  in_block,
    input  logic              key_we,
    input  logic [KIDX_W-1:0] key_idx,
    input  logic [BLK_W-1:0]  key_word,
    output logic              out_valid,
    output logic [BLK_W-1:0]  out_block,
    output logic              busy
);
    localparam int NKEYS = ROUNDS + 1;

    logic [NKEYS-1:0][BLK_W-1:0] keys;
    logic [ROUNDS-1:0]           vld;
    logic [BLK_W-1:0]            stg  [ROUNDS];
    logic [BLK_W-1:0]            rin  [ROUNDS];
    logic [BLK_W-1:0]            sub  [ROUNDS];
    logic [BLK_W-1:0]            rout [ROUNDS];
    logic                        wr_ok;

    serpent_ctrl i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .inflight (|vld[ROUNDS-2:0]),
        .key_we   (key_we),
        .busy     (busy),
        .wr_ok    (wr_ok)
    );

    serpent_key_file #(.NKEYS(NKEYS), .KIDX_W(KIDX_W)) i_keys (
        .clk     (clk),
        .wr_ok   (wr_ok),
        .wr_idx  (key_idx),
        .wr_data (key_word),
        .keys    (keys)
    );

    for (genvar g = 0; g < ROUNDS; g++) begin : g_rnd
        if (g == 0) begin : g_first
            assign rin[g] = perm_in(in_block);
        end else begin : g_next
            assign rin[g] = stg[g-1];
        end

        serpent_mix_sub #(.RIDX(g)) i_ms (
            .blk     (rin[g]),
            .rkey    (keys[g]),
            .sub_out (sub[g])
        );

        if (g == ROUNDS - 1) begin : g_last
            assign rout[g] = sub[g] ^ keys[NKEYS-1];
        end else begin : g_mid
            assign rout[g] = perm_in(lin_sliced(perm_out(sub[g])));
        end

        always_ff @(posedge clk) stg[g] <= rout[g];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld <= '0;
        else        vld <= {vld[ROUNDS-2:0], in_valid};
    end

    assign out_valid = vld[ROUNDS-1];
    assign out_block = perm_out(stg[ROUNDS-1]);
endmodule

// File: rtl/serpent_pipe_chk.sv
module serpent_pipe_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid,
    input logic busy
);
    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> busy);

    // R7
    busy_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid));

    // R5
    out_within_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);

    // R5
    idle_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !in_valid) |=> !out_valid);

    // R8
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(out_valid));
endmodule

bind serpent_pipe serpent_pipe_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .busy      (busy)
);

// File: tb/test_serpent_pipe.sv
module test_serpent_pipe;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_block = '0;
    logic         key_we = 1'b0;
    logic [5:0]   key_idx = '0;
    logic [127:0] key_word = '0;
    logic         out_valid;
    logic [127:0] out_block;
    logic         busy;

    int errors = 0;
    int checks = 0;
    int unsigned cyc = 0;

    logic [127:0] mk [33];
    logic [127:0] exp_q [$];
    int unsigned  exp_c [$];
    string        exp_r [$];

    int sb [8][16] = '{
        '{3,8,15,1,10,6,5,11,14,13,4,2,7,0,9,12},
        '{15,12,2,7,9,0,5,10,1,11,14,8,6,13,3,4},
        '{8,6,7,9,3,12,10,15,13,1,14,4,0,11,5,2},
        '{0,15,11,8,12,9,6,3,13,1,2,4,10,7,5,14},
        '{1,15,8,3,12,0,11,6,2,5,4,10,9,14,7,13},
        '{15,5,2,11,4,10,9,12,0,3,14,8,13,6,7,1},
        '{7,2,12,5,8,4,6,11,14,9,1,15,13,3,10,0},
        '{1,13,15,0,14,8,2,11,7,4,12,10,9,3,5,6}
    };

    serpent_pipe i_serpent_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_block(in_block),
        .key_we(key_we), .key_idx(key_idx), .key_word(key_word),
        .out_valid(out_valid), .out_block(out_block), .busy(busy)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rl(input logic [31:0] w, input int s);
        return (w << s) | (w >> (32 - s));
    endfunction

    // Reference: words W[k] hold bit j of interleaved-domain bit 4j+k.
    function automatic logic [127:0] ref_enc(input logic [127:0] pt);
        logic [31:0] w [4];
        logic [31:0] kw [4];
        logic [31:0] t [4];
        for (int k = 0; k < 4; k++) w[k] = pt[32*k +: 32];
        for (int r = 0; r < 32; r++) begin
            for (int k = 0; k < 4; k++)
                for (int j = 0; j < 32; j++) kw[k][j] = mk[r][4*j+k];
            for (int k = 0; k < 4; k++) w[k] ^= kw[k];
            for (int j = 0; j < 32; j++) begin
                int v;
                v = sb[r % 8][{w[3][j], w[2][j], w[1][j], w[0][j]}];
                for (int k = 0; k < 4; k++) t[k][j] = v[k];
            end
            for (int k = 0; k < 4; k++) w[k] = t[k];
            if (r < 31) begin
                w[0] = rl(w[0], 13); w[2] = rl(w[2], 3);
                w[1] = w[1] ^ w[0] ^ w[2];
                w[3] = w[3] ^ w[2] ^ (w[0] << 3);
                w[1] = rl(w[1], 1); w[3] = rl(w[3], 7);
                w[0] = w[0] ^ w[1] ^ w[3];
                w[2] = w[2] ^ w[3] ^ (w[1] << 7);
                w[0] = rl(w[0], 5); w[2] = rl(w[2], 22);
            end else begin
                for (int k = 0; k < 4; k++)
                    for (int j = 0; j < 32; j++) kw[k][j] = mk[32][4*j+k];
                for (int k = 0; k < 4; k++) w[k] ^= kw[k];
            end
        end
        return {w[3], w[2], w[1], w[0]};
    endfunction

    function automatic logic [127:0] mix(input int unsigned a);
        logic [127:0] v;
        for (int q = 0; q < 4; q++) v[32*q +: 32] = (a + 32'h1234567 * (q + 1)) * 32'h9E3779B1 ^ (a << q);
        return v;
    endfunction

    // Output monitor: data (R2/R3/R4) and latency/order (R5)
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected out_valid", {127'b0, out_valid}, 128'd0);
            end else begin
                logic [127:0] e;
                int unsigned c;
                string r;
                e = exp_q.pop_front(); c = exp_c.pop_front(); r = exp_r.pop_front();
                chk(out_block === e, r, out_block, e);
                chk(cyc - c == 32, "R5 latency", 128'(cyc - c), 128'd32);
            end
        end
    end

    task automatic wr_key(input int idx, input logic [127:0] v, input bit expect_take);
        @(negedge clk);
        key_we = 1'b1; key_idx = 6'(idx); key_word = v;
        @(negedge clk);
        key_we = 1'b0;
        if (expect_take && idx < 33) mk[idx] = v;
    endtask

    task automatic send(input logic [127:0] p, input string req);
        in_valid = 1'b1; in_block = p;
        exp_q.push_back(ref_enc(p)); exp_c.push_back(cyc); exp_r.push_back(req);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((busy || exp_q.size() != 0) && n < 200) begin @(negedge clk); n++; end
        chk(exp_q.size() == 0, "R5 all outputs seen", 128'(exp_q.size()), 128'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", {127'b0, out_valid}, 128'd0);
        chk(busy == 1'b0, "R1 busy", {127'b0, busy}, 128'd0);
    endtask

    task automatic t_load();
        for (int i = 0; i < 33; i++) wr_key(i, mix(i + 77), 1'b1);
    endtask

    task automatic t_single_busy();
        @(negedge clk);
        send(mix(5), "R2 single block");
        for (int n = 1; n <= 33; n++) begin
            chk(busy == (n <= 32), "R7/R8 busy window", {127'b0, busy}, {127'b0, n <= 32});
            if (n == 32) chk(out_valid == 1'b1, "R5 out at 32", {127'b0, out_valid}, 128'd1);
            if (n < 33) @(negedge clk);
        end
        drain();
    endtask

    task automatic t_b2b();
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            in_valid = 1'b1; in_block = mix(1000 + i);
            exp_q.push_back(ref_enc(in_block)); exp_c.push_back(cyc); exp_r.push_back("R3 back-to-back");
            @(negedge clk);
        end
        in_valid = 1'b0;
        drain();
    endtask

    task automatic t_gaps();
        @(negedge clk);
        for (int i = 0; i < 24; i++) begin
            send(mix(3000 + i), "R3 gapped");
            for (int g = 0; g < (i % 4); g++) @(negedge clk);
        end
        drain();
    endtask

    task automatic t_locked_write();
        @(negedge clk);
        send(mix(42), "R7 write while busy dropped");
        wr_key(3, ~mix(9), 1'b0);
        wr_key(32, ~mix(8), 1'b0);
        drain();
        @(negedge clk);
        send(mix(43), "R7 next block after dropped write");
        drain();
    endtask

    task automatic t_same_cycle_write();
        @(negedge clk);
        key_we = 1'b1; key_idx = 6'd0; key_word = ~mix(1);
        send(mix(50), "R6 write with in_valid dropped");
        key_we = 1'b0;
        drain();
        @(negedge clk);
        send(mix(51), "R6 follow-up block");
        drain();
    endtask

    task automatic t_bad_index();
        wr_key(40, ~mix(2), 1'b0);
        wr_key(63, ~mix(3), 1'b0);
        @(negedge clk);
        send(mix(60), "R6 out-of-range index ignored");
        drain();
    endtask

    task automatic t_last_key();
        wr_key(32, mix(999), 1'b1);
        wr_key(31, mix(998), 1'b1);
        @(negedge clk);
        send(mix(70), "R4 new final keys");
        send(128'd0, "R4 zero plaintext");
        send({128{1'b1}}, "R2 ones plaintext");
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_single_busy();
        t_b2b();
        t_gaps();
        t_locked_write();
        t_same_cycle_write();
        t_bad_index();
        t_last_key();
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule